// File: doc/BRIEF.md
# Two-Way Latch/Register Bus Transceiver

This block links an A side and a B side with two independent 18-bit paths: one carries A data toward B, the other carries B data toward A. Each path has one storage element with three modes. A latch enable makes it transparent. A clock, gated by an active-low clock enable, loads it on a rising edge. With neither, it holds its value. Each path also has an active-low output enable. That enable becomes a drive-enable signal for the receiving side and a tri-stated pad output.

The whole block runs on one system clock. The direction clocks are sampled as ordinary signals, so a rising edge is seen when a direction clock is low in one system cycle and high in the next. Every input side has a drive-valid flag. While the flag is low, the path uses the last value captured while it was high. This models bus-hold. A synchronous reset clears both storage elements and both bus-hold registers.

Top module: `dual_path_xcvr`

## Requirements
- R1: After a synchronous reset, with latch enables low, both stored values read zero on the data outputs (`b_out` for A-to-B, `a_out` for B-to-A), and both drive enables are low while the output enables are high.
- R2: While `ab_le` is high, `b_out` follows the effective A input in the same cycle, with no clock edge needed.
- R3: While `ab_le` is low, `b_out` keeps its value when `ab_ck` stays high, stays low, or falls.
- R4: While `ab_le` and `ab_ce_n` are both low, a rising `ab_ck` (low in one sampled cycle, high in the next) loads the effective A input. The new value appears on `b_out` after the system clock edge at which the high level is first sampled.
- R5: While `ab_ce_n` is high, a rising `ab_ck` loads nothing.
- R6: A high `ab_le` overrides clocked loading at any level of `ab_ce_n`. When `ab_le` falls, the stored value is the input seen at the last system edge where `ab_le` was high.
- R7: When `ab_oe_n` is low, `b_oe` is high and `b_pad` carries `b_out`. When `ab_oe_n` is high, `b_oe` is low and `b_pad` is high-impedance. The A-side outputs follow `ba_oe_n` in the same way.
- R8: The B-to-A path behaves like the A-to-B path, using `ba_le`, `ba_ck`, `ba_ce_n` and `ba_oe_n`. Its operation does not disturb the A-to-B stored value.
- R9: While `a_in_drv` is low, the effective A input is the last `a_in` value sampled while `a_in_drv` was high, or zero after reset. The B side behaves the same way with `b_in_drv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | A-side data arriving at the block |
| a_in_drv | input | 1 | High while something external drives valid A data |
| b_in | input | 18 | B-side data arriving at the block |
| b_in_drv | input | 1 | High while something external drives valid B data |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (transparent when high) |
| ab_ck | input | 1 | A-to-B load clock, sampled |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (transparent when high) |
| ba_ck | input | 1 | B-to-A load clock, sampled |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| b_out | output | 18 | Data presented toward the B side |
| b_oe | output | 1 | B-side drive enable |
| b_pad | output | 18 | B-side tri-stated pad value |
| a_out | output | 18 | Data presented toward the A side |
| a_oe | output | 1 | A-side drive enable |
| a_pad | output | 18 | A-side tri-stated pad value |

## Verification
The assertions assume that no side is driven from outside while the block drives it. In other words, `b_oe` and `b_in_drv` are never high together, and neither are `a_oe` and `a_in_drv`. A monitor in the stimulus also reports any cycle where both output enables are low. The load and transparency properties compare against `a_in` or `b_in` only while the matching drive-valid flag is high, so bus-hold cases go to their own property. The directed tests change inputs one time unit after a system edge. Each direction clock is held for at least one whole system cycle, so every rising edge is sampled exactly once.

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         a_in_drv,
  input  logic [W-1:0] b_in,
  input  logic         b_in_drv,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_ck,
  input  logic         ab_ce_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_ck,
  input  logic         ba_ce_n,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output wire  [W-1:0] b_pad,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output wire  [W-1:0] a_pad
);
  logic [W-1:0] a_hold, b_hold, a_eff, b_eff, ab_q, ba_q;
  logic ab_ck_d, ba_ck_d, ab_load, ba_load;

  assign a_eff = a_in_drv ? a_in : a_hold;
  assign b_eff = b_in_drv ? b_in : b_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_hold <= '0;
      b_hold <= '0;
    end else begin
      if (a_in_drv) a_hold <= a_in;
      if (b_in_drv) b_hold <= b_in;
    end
  end

  always_ff @(posedge clk) begin
    ab_ck_d <= ab_ck;
    ba_ck_d <= ba_ck;
  end

  assign ab_load = ab_le | (ab_ck & ~ab_ck_d & ~ab_ce_n);
  assign ba_load = ba_le | (ba_ck & ~ba_ck_d & ~ba_ce_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q <= '0;
      ba_q <= '0;
    end else begin
      if (ab_load) ab_q <= a_eff;
      if (ba_load) ba_q <= b_eff;
    end
  end

  assign b_out = ab_le ? a_eff : ab_q;
  assign a_out = ba_le ? b_eff : ba_q;
  assign b_oe  = ~ab_oe_n;
  assign a_oe  = ~ba_oe_n;
  assign b_pad = b_oe ? b_out : 'z;
  assign a_pad = a_oe ? a_out : 'z;
endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic         a_in_drv,
  input logic [W-1:0] b_in,
  input logic         b_in_drv,
  input logic         ab_oe_n,
  input logic         ab_le,
  input logic         ab_ck,
  input logic         ab_ce_n,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic         ba_ck,
  input logic         ba_ce_n,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] a_out,
  input logic         a_oe
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && !ab_le && !ba_le |-> b_out == '0 && a_out == '0);
  // R2
  transp_ab_chk: assert property (@(posedge clk) disable iff (rst)
    ab_le && a_in_drv |-> b_out == a_in);
  // R3
  hold_ab_chk: assert property (@(posedge clk) disable iff (rst)
    !ab_le && ab_ce_n |=> ab_le || $stable(b_out));
  // R4
  load_ab_chk: assert property (@(posedge clk) disable iff (rst)
    !ab_le && !ab_ce_n && ab_ck && !$past(ab_ck) && a_in_drv |=> ab_le || b_out == $past(a_in));
  // R6
  prio_ab_chk: assert property (@(posedge clk) disable iff (rst)
    ab_le && a_in_drv |=> ab_le || b_out == $past(a_in));
  // R7
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ab_oe_n) |-> !b_oe);
  // R7
  clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(b_oe && b_in_drv) && !(a_oe && a_in_drv));
  // R8
  transp_ba_chk: assert property (@(posedge clk) disable iff (rst)
    ba_le && b_in_drv |-> a_out == b_in);
  // R8
  hold_ba_chk: assert property (@(posedge clk) disable iff (rst)
    !ba_le && ba_ce_n |=> ba_le || $stable(a_out));
  // R8
  load_ba_chk: assert property (@(posedge clk) disable iff (rst)
    !ba_le && !ba_ce_n && ba_ck && !$past(ba_ck) && b_in_drv |=> ba_le || a_out == $past(b_in));
  // R9
  bushold_ab_chk: assert property (@(posedge clk) disable iff (rst)
    a_in_drv |=> a_in_drv || !ab_le || b_out == $past(a_in));
endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.W(W)) chk_i (.*);

// File: tb/dual_path_xcvr_test.sv
module dual_path_xcvr_test;
  localparam int W = 18;
  logic clk = 0, rst = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_in_drv = 1, b_in_drv = 1;
  logic ab_oe_n = 1, ab_le = 0, ab_ck = 0, ab_ce_n = 1;
  logic ba_oe_n = 1, ba_le = 0, ba_ck = 0, ba_ce_n = 1;
  logic [W-1:0] b_out, a_out;
  wire  [W-1:0] b_pad, a_pad;
  logic b_oe, a_oe;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dual_path_xcvr #(.W(W)) uut (.*);

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  always @(negedge clk)
    if (!rst && !ab_oe_n && !ba_oe_n) begin
      fails++;
      $display("FAIL R7: actual both output enables low expected at most one");
    end

  task automatic t_reset;
    repeat (3) tick;
    rst = 0;
    tick;
    check("R1 b_out", b_out, '0);
    check("R1 a_out", a_out, '0);
    check("R1 b_oe", W'(b_oe), '0);
    check("R1 a_oe", W'(a_oe), '0);
  endtask

  task automatic t_transparent;
    ab_le = 1; a_in = 18'h1A5A5;
    #1 check("R2 same cycle", b_out, 18'h1A5A5);
    a_in = 18'h00F0F;
    #1 check("R2 follows", b_out, 18'h00F0F);
    tick;
    ab_le = 0;
    a_in = 18'h3FFFF;
    #1 check("R6 latched on fall", b_out, 18'h00F0F);
  endtask

  task automatic t_clocked;
    ab_ce_n = 0; ab_ck = 0; a_in = 18'h12345;
    tick;
    ab_ck = 1;
    tick;
    check("R4 rising load", b_out, 18'h12345);
    a_in = 18'h2AAAA;
    tick; tick;
    check("R3 steady high hold", b_out, 18'h12345);
    ab_ck = 0;
    tick;
    check("R3 falling hold", b_out, 18'h12345);
    tick;
    check("R3 steady low hold", b_out, 18'h12345);
    ab_ck = 1;
    tick;
    check("R4 second rise", b_out, 18'h2AAAA);
  endtask

  task automatic t_ce_block;
    ab_ce_n = 1; ab_ck = 0; a_in = 18'h05555;
    tick;
    ab_ck = 1;
    tick;
    check("R5 gated rise", b_out, 18'h2AAAA);
    ab_ck = 0;
    tick;
  endtask

  task automatic t_priority;
    ab_ce_n = 0; ab_le = 1; a_in = 18'h0BEEF;
    tick;
    ab_ck = 1; a_in = 18'h1CAFE;
    #1 check("R6 le over clock", b_out, 18'h1CAFE);
    tick;
    ab_le = 0; a_in = 18'h00001;
    #1 check("R6 after le fall", b_out, 18'h1CAFE);
    tick;
    check("R6 held", b_out, 18'h1CAFE);
    ab_ck = 0; ab_ce_n = 1;
    tick;
  endtask

  task automatic t_oe;
    b_in_drv = 0; ab_oe_n = 0;
    #1;
    check("R7 b_oe on", W'(b_oe), W'(1));
    check("R7 b_pad value", b_pad, 18'h1CAFE);
    ab_oe_n = 1;
    #1 check("R7 b_oe off", W'(b_oe), '0);
    b_in_drv = 1;
    tick;
  endtask

  task automatic t_reverse;
    ba_le = 1; b_in = 18'h3C3C3;
    #1 check("R8 transparent", a_out, 18'h3C3C3);
    tick;
    ba_le = 0; ba_ce_n = 0; ba_ck = 0; b_in = 18'h07777;
    tick;
    check("R8 held", a_out, 18'h3C3C3);
    ba_ck = 1;
    tick;
    check("R8 clocked", a_out, 18'h07777);
    check("R8 other path untouched", b_out, 18'h1CAFE);
    a_in_drv = 0; ba_oe_n = 0;
    #1;
    check("R7 a_oe on", W'(a_oe), W'(1));
    check("R7 a_pad value", a_pad, 18'h07777);
    ba_oe_n = 1;
    #1 check("R7 a_oe off", W'(a_oe), '0);
    a_in_drv = 1; ba_ck = 0; ba_ce_n = 1;
    tick;
  endtask

  task automatic t_bushold;
    a_in = 18'h24680; a_in_drv = 1;
    tick;
    a_in_drv = 0; a_in = 18'h3FFFF; ab_le = 1;
    #1 check("R9 held input", b_out, 18'h24680);
    tick;
    check("R9 still held", b_out, 18'h24680);
    ab_le = 0; a_in_drv = 1;
    b_in = 18'h13579;
    tick;
    b_in_drv = 0; b_in = '0; ba_le = 1;
    #1 check("R9 B side held", a_out, 18'h13579);
    ba_le = 0; b_in_drv = 1;
    tick;
  endtask

  initial begin
    #1600000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1;
    t_reset;
    t_transparent;
    t_clocked;
    t_ce_block;
    t_priority;
    t_oe;
    t_reverse;
    t_bushold;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule